// File: doc/BRIEF.md
# DMA channel control and status register block

This block is the software-facing register file of a multi-channel DMA controller with up to twelve channels. A simple 32-bit register bus (word address, write enable, write data, read enable, read data) sets each channel's operating mode and transfer direction, sets the per-channel interrupt enables, and reads back sticky completion and error flags together with each engine's live 2-bit state. The transfer engines and the descriptor memory sit outside the block.

Every channel owns a 4-bit control field. Channels 0 to 7 pack their fields into the low control word; channels 8 to 11 use the same packing in a second control word. Writing an active mode to an idle channel, or hitting its start bit, sends that engine a one-cycle start pulse. Writing the off mode pulls the engine back to idle through its mode output. Completion and error pulses from the engines raise sticky flags that software clears by writing ones. A single level interrupt line is high while any enabled completion flag is pending.

Top module: `dma_csr_regs`

## Requirements
- R1: After reset every mode and direction output, start pulse, enable, flag and the interrupt line are 0, and the read data is 0.
- R2: Channel c < 8 has its control field at offset 0x00, bits [4c+3:4c]. Channel c ≥ 8 has it at offset 0x0C, bits [4(c-8)+3:4(c-8)]. Field bits [1:0] are the mode (0 off, 1 descriptor chain, 2 single block). Bit 2 is the direction (1 memory to device, 0 device to memory). Bit 3 reads 0. The mode and direction outputs follow in the cycle after the write, and the field reads back.
- R3: A field written with mode 3 is ignored. That channel keeps its previous mode and direction.
- R4: Writing mode 1 or 2 to a channel whose state input is 0 (idle) raises its start output for exactly the one cycle after the write. No start is raised while the state is nonzero, or for mode 0.
- R5: Writing 1 to bit 8+c of offset 0x08 pulses channel c's start in the next cycle, if its mode is nonzero and its state is idle. These bits read back as 0.
- R6: The interrupt enables for channels 0 to 7 are bits [7:0] of offset 0x08. Those for channels 8 to 11 are bits [3:0] of offset 0x04. Both read back.
- R7: A completion pulse sets the channel's interrupt flag. An error pulse sets both its interrupt flag and its error flag. For c < 8 these flags are bits c and c+8 of offset 0x10. For c ≥ 8 they are bits c-8 and c of offset 0x14.
- R8: Writing 1 to a flag bit clears it and writing 0 leaves it alone. A set and a clear of the same flag in the same cycle leave it set.
- R9: The live 2-bit state of channel c < 8 reads at bits [17+2c:16+2c] of offset 0x10. For c ≥ 8 it reads at bits [17+2(c-8):16+2(c-8)] of offset 0x14.
- R10: The interrupt line is the OR over all channels of interrupt flag AND enable. It changes in the cycle after the flag or enable changes.
- R11: Read data is registered and appears in the cycle after the read enable. Unmapped word offsets (0x18 and above) read 0. Without a read enable the read data holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Byte address of the register |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| ch_mode_o | output | 2*NUM_CH | Mode per channel, 2 bits each |
| ch_dir_o | output | NUM_CH | Direction per channel |
| ch_start_o | output | NUM_CH | One-cycle start pulse per channel |
| ch_state_i | input | 2*NUM_CH | Live engine state per channel |
| ch_done_i | input | NUM_CH | Completion pulse per channel |
| ch_err_i | input | NUM_CH | Error pulse per channel |
| irq_o | output | 1 | Level interrupt |

## Verification
Two functions can land on the same flag in one cycle: an engine raising a completion, and software writing a one to clear that same flag. The bench drives a completion pulse and a clear write to the status word on the same clock edge. It then reads the flag back and expects it still set, while a clear written in a quiet cycle must drop the flag. A second overlap is a mode write arriving while an engine reports a busy state. Here the start pulse must be withheld for that channel alone, and the other channels written in the same word must still start.

// File: rtl/dmacsr_pkg.sv
package dmacsr_pkg;
  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_CHAIN  = 2'd1,
    MODE_SINGLE = 2'd2,
    MODE_RSVD   = 2'd3
  } ch_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DESC = 2'd1,
    ST_WAIT = 2'd2,
    ST_XFER = 2'd3
  } ch_state_e;

  // word indices (byte offset / 4)
  localparam int WI_CTRL_LO = 0;
  localparam int WI_EN_HI   = 1;
  localparam int WI_IRQ     = 2;
  localparam int WI_CTRL_HI = 3;
  localparam int WI_STAT_LO = 4;
  localparam int WI_STAT_HI = 5;

  localparam int LO_CH      = 8;
  localparam int NIB_W      = 4;
  localparam int START_LSB  = 8;
  localparam int ERR_LSB    = 8;
  localparam int STATE_LSB  = 16;
endpackage

// File: rtl/dmacsr_decode.sv
module dmacsr_decode #(
  parameter int AW = 8
) (
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  output logic [AW-3:0] word_o,
  output logic          we_ctrl_lo_o,
  output logic          we_en_hi_o,
  output logic          we_irq_o,
  output logic          we_ctrl_hi_o,
  output logic          we_stat_lo_o,
  output logic          we_stat_hi_o
);
  import dmacsr_pkg::*;
  localparam int WI_W = AW - 2;

  logic aligned;
  assign aligned = (addr_i[1:0] == 2'b00);
  assign word_o  = addr_i[AW-1:2];

  always_comb begin
    we_ctrl_lo_o = wr_en_i && aligned && (word_o == WI_W'(WI_CTRL_LO));
    we_en_hi_o   = wr_en_i && aligned && (word_o == WI_W'(WI_EN_HI));
    we_irq_o     = wr_en_i && aligned && (word_o == WI_W'(WI_IRQ));
    we_ctrl_hi_o = wr_en_i && aligned && (word_o == WI_W'(WI_CTRL_HI));
    we_stat_lo_o = wr_en_i && aligned && (word_o == WI_W'(WI_STAT_LO));
    we_stat_hi_o = wr_en_i && aligned && (word_o == WI_W'(WI_STAT_HI));
  end
endmodule

// File: rtl/dmacsr_chan.sv
module dmacsr_chan (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_we_i,
  input  logic [2:0] cfg_nib_i,
  input  logic       en_we_i,
  input  logic       en_i,
  input  logic       kick_i,
  input  logic       clr_irq_i,
  input  logic       clr_err_i,
  input  logic [1:0] state_i,
  input  logic       done_i,
  input  logic       err_i,
  output logic [1:0] mode_o,
  output logic       dir_o,
  output logic       en_o,
  output logic       irq_flag_o,
  output logic       err_flag_o,
  output logic       start_o
);
  import dmacsr_pkg::*;

  ch_mode_e mode_q;
  logic     dir_q, en_q, irq_q, err_q, start_q;
  logic     mode_ok, idle, go;

  assign mode_ok = cfg_we_i && (ch_mode_e'(cfg_nib_i[1:0]) != MODE_RSVD);
  assign idle    = (ch_state_e'(state_i) == ST_IDLE);
  assign go      = idle && ((mode_ok && (ch_mode_e'(cfg_nib_i[1:0]) != MODE_OFF)) ||
                            (kick_i && (mode_q != MODE_OFF)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_OFF;
      dir_q   <= 1'b0;
      en_q    <= 1'b0;
      irq_q   <= 1'b0;
      err_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      if (mode_ok) begin
        mode_q <= ch_mode_e'(cfg_nib_i[1:0]);
        dir_q  <= cfg_nib_i[2];
      end
      if (en_we_i) en_q <= en_i;
      // set beats clear
      if (done_i || err_i) irq_q <= 1'b1;
      else if (clr_irq_i)  irq_q <= 1'b0;
      if (err_i)           err_q <= 1'b1;
      else if (clr_err_i)  err_q <= 1'b0;
      start_q <= go;
    end
  end

  assign mode_o     = mode_q;
  assign dir_o      = dir_q;
  assign en_o       = en_q;
  assign irq_flag_o = irq_q;
  assign err_flag_o = err_q;
  assign start_o    = start_q;

  // R4
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> ($past(state_i) == 2'd0));
  // R3
  rsvd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_nib_i[1:0] == 2'd3) |=> ($stable(mode_o) && $stable(dir_o)));
  // R7
  err_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> (irq_flag_o && err_flag_o));
  // R8
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && clr_irq_i) |=> irq_flag_o);
  // R8
  w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_irq_i && !done_i && !err_i) |=> !irq_flag_o);
endmodule

// File: rtl/dmacsr_rdmux.sv
module dmacsr_rdmux #(
  parameter int NUM_CH = 12,
  parameter int AW     = 8
) (
  input  logic [AW-3:0]       word_i,
  input  logic [2*NUM_CH-1:0] mode_i,
  input  logic [NUM_CH-1:0]   dir_i,
  input  logic [NUM_CH-1:0]   en_i,
  input  logic [NUM_CH-1:0]   irq_i,
  input  logic [NUM_CH-1:0]   err_i,
  input  logic [2*NUM_CH-1:0] state_i,
  output logic [31:0]         rd_word_o
);
  import dmacsr_pkg::*;
  localparam int WI_W = AW - 2;

  logic [31:0] ctrl_lo, ctrl_hi, en_hi, irq_w, stat_lo, stat_hi;

  always_comb begin
    ctrl_lo = '0; ctrl_hi = '0; en_hi = '0;
    irq_w   = '0; stat_lo = '0; stat_hi = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (c < LO_CH) begin
        ctrl_lo[NIB_W*(c % LO_CH) +: NIB_W]     = {1'b0, dir_i[c], mode_i[2*c +: 2]};
        irq_w[c % LO_CH]                         = en_i[c];
        stat_lo[c % LO_CH]                       = irq_i[c];
        stat_lo[ERR_LSB + (c % LO_CH)]           = err_i[c];
        stat_lo[STATE_LSB + 2*(c % LO_CH) +: 2]  = state_i[2*c +: 2];
      end else begin
        ctrl_hi[NIB_W*(c % LO_CH) +: NIB_W]     = {1'b0, dir_i[c], mode_i[2*c +: 2]};
        en_hi[c % LO_CH]                         = en_i[c];
        stat_hi[c % LO_CH]                       = irq_i[c];
        stat_hi[ERR_LSB + (c % LO_CH)]           = err_i[c];
        stat_hi[STATE_LSB + 2*(c % LO_CH) +: 2]  = state_i[2*c +: 2];
      end
    end
  end

  always_comb begin
    unique case (word_i)
      WI_W'(WI_CTRL_LO): rd_word_o = ctrl_lo;
      WI_W'(WI_EN_HI):   rd_word_o = en_hi;
      WI_W'(WI_IRQ):     rd_word_o = irq_w;
      WI_W'(WI_CTRL_HI): rd_word_o = ctrl_hi;
      WI_W'(WI_STAT_LO): rd_word_o = stat_lo;
      WI_W'(WI_STAT_HI): rd_word_o = stat_hi;
      default:           rd_word_o = '0;
    endcase
  end
endmodule

// File: rtl/dma_csr_regs.sv
module dma_csr_regs #(
  parameter int NUM_CH = 12,
  parameter int AW     = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [AW-1:0]       addr_i,
  input  logic                wr_en_i,
  input  logic [31:0]         wdata_i,
  input  logic                rd_en_i,
  output logic [31:0]         rdata_o,
  output logic [2*NUM_CH-1:0] ch_mode_o,
  output logic [NUM_CH-1:0]   ch_dir_o,
  output logic [NUM_CH-1:0]   ch_start_o,
  input  logic [2*NUM_CH-1:0] ch_state_i,
  input  logic [NUM_CH-1:0]   ch_done_i,
  input  logic [NUM_CH-1:0]   ch_err_i,
  output logic                irq_o
);
  import dmacsr_pkg::*;
  localparam int WI_W = AW - 2;

  logic [WI_W-1:0]   word;
  logic              we_ctrl_lo, we_en_hi, we_irq, we_ctrl_hi, we_stat_lo, we_stat_hi;
  logic [NUM_CH-1:0] en, irq_flag, err_flag;
  logic [31:0]       rd_word, rdata_q;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i;

  dmacsr_decode #(.AW(AW)) u_decode (
    .addr_i       (addr_i),
    .wr_en_i      (wr_en_i),
    .word_o       (word),
    .we_ctrl_lo_o (we_ctrl_lo),
    .we_en_hi_o   (we_en_hi),
    .we_irq_o     (we_irq),
    .we_ctrl_hi_o (we_ctrl_hi),
    .we_stat_lo_o (we_stat_lo),
    .we_stat_hi_o (we_stat_hi)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int LC = c % LO_CH;
    logic cfg_we, en_we, clr_irq, clr_err;
    if (c < LO_CH) begin : g_lo
      assign cfg_we  = we_ctrl_lo;
      assign en_we   = we_irq;
      assign clr_irq = we_stat_lo;
      assign clr_err = we_stat_lo;
    end else begin : g_hi
      assign cfg_we  = we_ctrl_hi;
      assign en_we   = we_en_hi;
      assign clr_irq = we_stat_hi;
      assign clr_err = we_stat_hi;
    end

    dmacsr_chan u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_we_i   (cfg_we),
      .cfg_nib_i  (wdata_i[NIB_W*LC +: 3]),
      .en_we_i    (en_we),
      .en_i       (wdata_i[LC]),
      .kick_i     (we_irq && wdata_i[START_LSB + c]),
      .clr_irq_i  (clr_irq && wdata_i[LC]),
      .clr_err_i  (clr_err && wdata_i[ERR_LSB + LC]),
      .state_i    (ch_state_i[2*c +: 2]),
      .done_i     (ch_done_i[c]),
      .err_i      (ch_err_i[c]),
      .mode_o     (ch_mode_o[2*c +: 2]),
      .dir_o      (ch_dir_o[c]),
      .en_o       (en[c]),
      .irq_flag_o (irq_flag[c]),
      .err_flag_o (err_flag[c]),
      .start_o    (ch_start_o[c])
    );
  end

  dmacsr_rdmux #(.NUM_CH(NUM_CH), .AW(AW)) u_rdmux (
    .word_i    (word),
    .mode_i    (ch_mode_o),
    .dir_i     (ch_dir_o),
    .en_i      (en),
    .irq_i     (irq_flag),
    .err_i     (err_flag),
    .state_i   (ch_state_i),
    .rd_word_o (rd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_word;
  end

  assign rdata_o = rdata_q;
  assign irq_o   = |(irq_flag & en);

  // R11
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (addr_i[AW-1:2] > WI_W'(WI_STAT_HI))) |=> (rdata_o == 32'd0));
  // R11
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: tb/dma_csr_regs_bench.sv
module dma_csr_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 12;

  logic            clk_i = 1'b0;
  logic            rst_ni;
  logic [7:0]      addr_i;
  logic            wr_en_i, rd_en_i;
  logic [31:0]     wdata_i, rdata_o;
  logic [2*NCH-1:0] ch_mode_o, ch_state_i;
  logic [NCH-1:0]  ch_dir_o, ch_start_o, ch_done_i, ch_err_i;
  logic            irq_o;

  int total = 0;
  int bad   = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dma_csr_regs #(.NUM_CH(NCH), .AW(8)) u_dma_csr_regs (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .wdata_i, .rd_en_i, .rdata_o,
    .ch_mode_o, .ch_dir_o, .ch_start_o, .ch_state_i, .ch_done_i, .ch_err_i, .irq_o
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor: compares registered read data against the scoreboard queue
  always @(posedge clk_i) rd_seen <= rd_en_i && rst_ni;
  always @(negedge clk_i) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) chk("R11 unexpected read", rdata_o, 32'hxxxx_xxxx);
      else chk(tag_q.pop_front(), rdata_o, exp_q.pop_front());
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] e, string tag);
    @(negedge clk_i);
    addr_i = a; rd_en_i = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic pulse(logic [NCH-1:0] d, logic [NCH-1:0] e);
    @(negedge clk_i);
    ch_done_i = d; ch_err_i = e;
    @(negedge clk_i);
    ch_done_i = '0; ch_err_i = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0; addr_i = '0; wdata_i = '0; wr_en_i = 1'b0; rd_en_i = 1'b0;
    ch_state_i = '0; ch_done_i = '0; ch_err_i = '0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 mode", 32'(ch_mode_o), 0);
    chk("R1 start", 32'(ch_start_o), 0);
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 rdata", rdata_o, 0);
    rst_ni = 1'b1;
    rd(8'h00, 32'h0, "R1 ctrl lo");
    rd(8'h10, 32'h0, "R1 stat lo");

    // R2/R4 low control word: ch0 single+mem->dev, ch1 chain, ch2 bit3 only, ch7 single
    wr(8'h00, 32'h2000_0816);
    chk("R4 start pulse", 32'(ch_start_o), 32'h083);
    chk("R2 ch0 mode", 32'(ch_mode_o[1:0]), 2);
    chk("R2 ch0 dir", 32'(ch_dir_o[0]), 1);
    @(negedge clk_i);
    chk("R4 single cycle", 32'(ch_start_o), 0);
    rd(8'h00, 32'h2000_0016, "R2 readback");

    // R3 mode 3 on ch0 ignored
    wr(8'h00, 32'h2000_0017);
    chk("R3 no start", 32'(ch_start_o), 32'h082);
    chk("R3 dir held", 32'(ch_dir_o[0]), 1);
    rd(8'h00, 32'h2000_0016, "R3 readback");

    // R4 busy channel 1 withholds start; R9 state readback
    ch_state_i[3:2] = 2'd2;
    wr(8'h00, 32'h2000_0016);
    chk("R4 busy", 32'(ch_start_o), 32'h081);
    rd(8'h10, 32'h0008_0000, "R9 state lo");
    ch_state_i = '0;

    // R2 upper control word
    wr(8'h0C, 32'h0000_6201);
    chk("R4 hi start", 32'(ch_start_o), 32'hD00);
    chk("R2 ch8 mode", 32'(ch_mode_o[17:16]), 1);
    chk("R2 ch11 dir", 32'(ch_dir_o[11]), 1);
    rd(8'h0C, 32'h0000_6201, "R2 hi readback");

    // R5 start field (ch2 has mode off)
    wr(8'h08, 32'h0000_0700);
    chk("R5 start field", 32'(ch_start_o), 32'h003);
    rd(8'h08, 32'h0, "R5 reads zero");

    // R6 enables
    wr(8'h08, 32'h0000_00A5);
    chk("R5 no kick", 32'(ch_start_o), 0);
    wr(8'h04, 32'h0000_0009);
    rd(8'h08, 32'h0000_00A5, "R6 en lo");
    rd(8'h04, 32'h0000_0009, "R6 en hi");

    // R7/R10 flags
    pulse(12'h002, 12'h000);
    chk("R10 masked", 32'(irq_o), 0);
    rd(8'h10, 32'h0000_0002, "R7 done flag");
    pulse(12'h000, 12'h001);
    chk("R10 irq up", 32'(irq_o), 1);
    rd(8'h10, 32'h0000_0103, "R7 err flags");

    // R8 write-one-to-clear
    wr(8'h10, 32'h0000_0001);
    chk("R10 irq down", 32'(irq_o), 0);
    rd(8'h10, 32'h0000_0102, "R8 clear one");
    wr(8'h10, 32'h0000_0000);
    rd(8'h10, 32'h0000_0102, "R8 zero no effect");
    @(negedge clk_i);
    ch_done_i = 12'h002; addr_i = 8'h10; wdata_i = 32'h2; wr_en_i = 1'b1;
    @(negedge clk_i);
    ch_done_i = '0; wr_en_i = 1'b0;
    rd(8'h10, 32'h0000_0102, "R8 set wins");
    wr(8'h10, 32'h0000_0102);
    rd(8'h10, 32'h0, "R8 all clear");

    // R7/R9/R10 upper channels
    ch_state_i = 24'h0C_0000;
    pulse(12'h100, 12'h800);
    chk("R10 hi irq", 32'(irq_o), 1);
    rd(8'h14, 32'h000C_0809, "R7 R9 stat hi");
    wr(8'h14, 32'h0000_0809);
    chk("R10 hi clear", 32'(irq_o), 0);
    rd(8'h14, 32'h000C_0000, "R8 hi clear");
    ch_state_i = '0;

    // R11 unmapped and hold
    rd(8'h18, 32'h0, "R11 unmapped 18");
    rd(8'h3C, 32'h0, "R11 unmapped 3C");
    rd(8'h04, 32'h0000_0009, "R11 read");
    repeat (3) @(negedge clk_i);
    chk("R11 hold", rdata_o, 32'h0000_0009);

    repeat (2) @(negedge clk_i);
    if (exp_q.size() != 0) chk("R11 pending reads", 32'(exp_q.size()), 0);
    finish_run();
  end
endmodule